// File: doc/BRIEF.md
# Instruction Fetch and Delayed-Branch Unit

This block is the front end of a small pipelined controller. It holds the instruction pointer, presents it as the address of an on-chip synchronous instruction RAM, and passes the 32-bit word that comes back one cycle later to the decode stage. The word is tagged with a valid flag and with the address it came from. The RAM never stalls and never misses, so the pointer moves every cycle.

The decode stage resolves control flow in the cycle after fetch. It sends back a request that carries a kind code, a 32-bit register value and a target address. Two conditional kinds test the register value: one for zero and one for non-zero. A direct jump is always taken. A register-indirect jump is always taken and gets its target from the low address bits of the register value.

By the time a redirect arrives, the word after the branch is already being read. That word is always delivered and executed: there is exactly one architectural delay slot. A branch placed inside the delay slot of another branch also works. The result is the delay-slot word, then the first target, then the second target.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `fetch_valid` is 0 on the clock edge after reset is sampled.
- R2: After `rst_n` is released, `fetch_valid` stays low for exactly one cycle. It then rises with `fetch_pc` = 0 and `fetch_instr` equal to the word at address 0.
- R3: With no taken redirect, `imem_addr` advances by one each cycle and wraps from 2^ADDR_W-1 to 0.
- R4: While `fetch_valid` is high, `fetch_instr` is the RAM word for `fetch_pc`, and `fetch_pc` is the address that was presented one cycle earlier.
- R5: Kind 2'b00 (branch if zero) with `br_operand` = 0 makes the next `imem_addr` equal to `br_target`.
- R6: Kind 2'b01 (branch if non-zero) with `br_operand` ≠ 0 makes the next `imem_addr` equal to `br_target`.
- R7: A conditional kind whose test fails leaves fetch sequential, so the next `imem_addr` is the current one plus one.
- R8: After a request is accepted, the next fetched word is the one whose address was presented in the request cycle, whether or not the branch is taken. For a branch at P that was not itself in a delay slot, this is P+1.
- R9: Kind 2'b10 (direct jump) is always taken to `br_target`, whatever the value of `br_operand`.
- R10: Kind 2'b11 (register jump) is always taken to `br_operand[ADDR_W-1:0]`; `br_target` has no effect.
- R11: A request presented while `fetch_valid` is low has no effect on the fetch sequence.
- R12: A taken branch placed in the delay slot of a taken branch fetches the first target next, then the second target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | ADDR_W | Word address to the instruction RAM |
| imem_rdata | input | DATA_W | RAM read data, returned one cycle after the address |
| fetch_valid | output | 1 | Fetched word to decode is valid |
| fetch_instr | output | DATA_W | Fetched instruction word |
| fetch_pc | output | ADDR_W | Address of the fetched word |
| br_req | input | 1 | Decode presents a control-flow request for the current fetched word |
| br_kind | input | 2 | 00 branch if zero, 01 branch if non-zero, 10 direct jump, 11 register jump |
| br_operand | input | DATA_W | Register value that is tested, or the register-jump target |
| br_target | input | ADDR_W | Target address for branches and direct jumps |

## Verification
The assertions assume the instruction RAM answers every address with its word on exactly the next edge. They also assume decode raises `br_req` only in cycles that belong to a word on the fetch output, holding it for that single cycle. The bench meets both conditions by modelling the RAM as one registered lookup of a computed word. It changes the request inputs only at falling edges, and it lowers `br_req` again one cycle after raising it. The one deliberate exception is the request made during the invalid cycle after reset, which checks that such a request is ignored (R11).

// File: rtl/ifu_pkg.sv
// Package: shared types for the instruction fetch unit.
// Assumes: the redirect kind arrives as a 2-bit code from decode.
package ifu_pkg;

    // Encoding of the control-flow request kind sent back by decode.
    typedef enum logic [1:0] {
        RK_IF_ZERO    = 2'b00,
        RK_IF_NONZERO = 2'b01,
        RK_JUMP       = 2'b10,
        RK_JUMP_REG   = 2'b11
    } redir_kind_e;

    // True for the two kinds whose outcome depends on the register value.
    function automatic logic is_conditional(input redir_kind_e k);
        return (k == RK_IF_ZERO) || (k == RK_IF_NONZERO);
    endfunction

endpackage

// File: rtl/ifu_cond_eval.sv
// Module: ifu_cond_eval
// Decides whether a control-flow request is taken. Conditional kinds test
// one register value for zero or non-zero; both jump kinds are forced taken.
// Assumes: the operand is the already-read register value; purely combinational.
module ifu_cond_eval
    import ifu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  redir_kind_e         kind,
    input  logic [DATA_W-1:0]   operand,
    output logic                taken
);

    logic is_zero;

    // Zero detect over the whole register value.
    always_comb begin
        is_zero = (operand == '0);
    end

    // Select the outcome by kind; jumps ignore the operand test.
    always_comb begin
        if (is_conditional(kind)) begin
            taken = (kind == RK_IF_ZERO) ? is_zero : !is_zero;
        end else begin
            taken = 1'b1;
        end
    end

endmodule

// File: rtl/ifu_target_sel.sv
// Module: ifu_target_sel
// Picks the redirect destination: the request's target field for branches
// and direct jumps, or the truncated register value for a register jump.
// Assumes: the caller has already cut the register value to ADDR_W bits.
module ifu_target_sel
    import ifu_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  redir_kind_e         kind,
    input  logic [ADDR_W-1:0]   field_target,
    input  logic [ADDR_W-1:0]   reg_target,
    output logic [ADDR_W-1:0]   dest
);

    // Destination multiplexer keyed on the request kind.
    always_comb begin
        unique case (kind)
            RK_JUMP_REG: dest = reg_target;
            default:     dest = field_target;
        endcase
    end

endmodule

// File: rtl/ifu_pc_reg.sv
// Module: ifu_pc_reg
// Holds the instruction pointer that drives the instruction RAM address.
// Each cycle it moves to the next word, or to the redirect destination.
// Assumes: synchronous active-low reset; a redirect is already qualified.
module ifu_pc_reg #(
    parameter int              ADDR_W   = 9,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                redirect,
    input  logic [ADDR_W-1:0]   dest,
    output logic [ADDR_W-1:0]   pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    // Next-pointer choice: redirect wins, otherwise sequential with wrap.
    always_comb begin
        pc_d = redirect ? dest : (pc_q + STEP);
    end

    // Pointer register with synchronous reset to the start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/ifu_fetch_stage.sv
// Module: ifu_fetch_stage
// Tracks which address the RAM is answering this cycle and whether that
// answer is real, so decode gets a valid flag and the word's address.
// Assumes: the RAM returns data exactly one cycle after the address.
module ifu_fetch_stage #(
    parameter int ADDR_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   issued_addr,
    output logic                valid,
    output logic [ADDR_W-1:0]   word_addr
);

    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;

    // Valid flag: low in reset, high from the first edge after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b1;
        end
    end

    // Address shadow: follows the RAM address by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= issued_addr;
        end
    end

    assign valid     = valid_q;
    assign word_addr = addr_q;

endmodule

// File: rtl/ifu_fetch_unit.sv
// Module: ifu_fetch_unit (top)
// Instruction fetch with a single architectural delay slot. The pointer
// addresses a synchronous instruction RAM; the word returns next cycle and
// goes to decode. Decode answers in that same cycle with a control-flow
// request; a taken request changes the pointer after the word already in
// flight, which becomes the delay slot.
// Assumes: miss-free RAM with one-cycle latency; requests only count while
// a valid word is on the fetch output.
module ifu_fetch_unit
    import ifu_pkg::*;
#(
    parameter int                ADDR_W   = 9,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   imem_addr,
    input  logic [DATA_W-1:0]   imem_rdata,
    output logic                fetch_valid,
    output logic [DATA_W-1:0]   fetch_instr,
    output logic [ADDR_W-1:0]   fetch_pc,
    input  logic                br_req,
    input  logic [1:0]          br_kind,
    input  logic [DATA_W-1:0]   br_operand,
    input  logic [ADDR_W-1:0]   br_target
);

    redir_kind_e        kind;
    logic               cond_taken;
    logic               redirect;
    logic [ADDR_W-1:0]  dest;
    logic [ADDR_W-1:0]  pc;
    logic               valid;
    logic [ADDR_W-1:0]  word_addr;

    // Interpret the raw kind code as the shared enum.
    always_comb begin
        kind = redir_kind_e'(br_kind);
    end

    ifu_cond_eval #(
        .DATA_W (DATA_W)
    ) u_cond (
        .kind    (kind),
        .operand (br_operand),
        .taken   (cond_taken)
    );

    ifu_target_sel #(
        .ADDR_W (ADDR_W)
    ) u_tsel (
        .kind         (kind),
        .field_target (br_target),
        .reg_target   (br_operand[ADDR_W-1:0]),
        .dest         (dest)
    );

    // Qualify the request: only a valid fetched word may redirect.
    always_comb begin
        redirect = br_req && valid && cond_taken;
    end

    ifu_pc_reg #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .dest     (dest),
        .pc       (pc)
    );

    ifu_fetch_stage #(
        .ADDR_W (ADDR_W)
    ) u_fs (
        .clk         (clk),
        .rst_n       (rst_n),
        .issued_addr (pc),
        .valid       (valid),
        .word_addr   (word_addr)
    );

    assign imem_addr   = pc;
    assign fetch_valid = valid;
    assign fetch_pc    = word_addr;
    assign fetch_instr = imem_rdata;

endmodule

// File: rtl/ifu_fetch_unit_chk.sv
// Module: ifu_fetch_unit_chk
// Property checker for the fetch unit, bound to every instance of the top.
// Assumes: requests are only meaningful while fetch_valid is high.
module ifu_fetch_unit_chk #(
    parameter int                ADDR_W   = 9,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   imem_addr,
    input logic                fetch_valid,
    input logic [ADDR_W-1:0]   fetch_pc,
    input logic                br_req,
    input logic [1:0]          br_kind,
    input logic [DATA_W-1:0]   br_operand,
    input logic [ADDR_W-1:0]   br_target
);

    logic op_zero;
    logic acc;
    always_comb begin
        op_zero = (br_operand == '0);
        acc     = br_req && fetch_valid;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == RESET_PC) && !fetch_valid);

    assert_first_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fetch_valid);

    assert_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> fetch_valid && fetch_pc == RESET_PC);

    assert_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

    assert_word_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid || fetch_pc == $past(imem_addr));

    assert_if_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && br_kind == 2'b00 && op_zero |=> imem_addr == $past(br_target));

    assert_if_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && br_kind == 2'b01 && !op_zero |=> imem_addr == $past(br_target));

    assert_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ((br_kind == 2'b00 && !op_zero) || (br_kind == 2'b01 && op_zero))
        |=> imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

    assert_delay_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> fetch_valid && fetch_pc == $past(imem_addr));

    assert_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc && br_kind == 2'b10 |=> imem_addr == $past(br_target));

    assert_jump_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc && br_kind == 2'b11 |=> imem_addr == $past(br_operand[ADDR_W-1:0]));

    assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        br_req && !fetch_valid |=> imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

endmodule

bind ifu_fetch_unit ifu_fetch_unit_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .imem_addr   (imem_addr),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .br_req      (br_req),
    .br_kind     (br_kind),
    .br_operand  (br_operand),
    .br_target   (br_target)
);

// File: tb/ifu_fetch_unit_test.sv
// Directed bench for ifu_fetch_unit: a computed-content RAM model plus a
// reference model of the instruction pointer, one task per scenario.
module ifu_fetch_unit_test;

    localparam int AW = 9;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [DW-1:0] imem_rdata = '0;
    logic          fetch_valid;
    logic [DW-1:0] fetch_instr;
    logic [AW-1:0] fetch_pc;
    logic          br_req = 1'b0;
    logic [1:0]    br_kind = 2'b00;
    logic [DW-1:0] br_operand = '0;
    logic [AW-1:0] br_target = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] ref_addr;
    logic [AW-1:0] ref_fpc;
    logic          ref_valid;

    always #2 clk = ~clk;

    ifu_fetch_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk (clk), .rst_n (rst_n), .imem_addr (imem_addr), .imem_rdata (imem_rdata),
        .fetch_valid (fetch_valid), .fetch_instr (fetch_instr), .fetch_pc (fetch_pc),
        .br_req (br_req), .br_kind (br_kind), .br_operand (br_operand), .br_target (br_target)
    );

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return 32'h5EED_0000 | 32'(a);
    endfunction

    // Instruction RAM model: word for the address, one cycle later.
    always_ff @(posedge clk) imem_rdata <= word_at(imem_addr);

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle with the given request; reference model updated and compared.
    task automatic advance(input logic req, input logic [1:0] kind, input logic [DW-1:0] opnd,
                           input logic [AW-1:0] tgt, input string tag);
        logic tk;
        br_req = req; br_kind = kind; br_operand = opnd; br_target = tgt;
        tk = ref_valid && req && (kind[1] || (kind == 2'b00 && opnd == '0) ||
                                  (kind == 2'b01 && opnd != '0));
        ref_fpc  = ref_addr;
        ref_addr = tk ? ((kind == 2'b11) ? opnd[AW-1:0] : tgt) : AW'(ref_addr + 1'b1);
        ref_valid = 1'b1;
        @(negedge clk);
        br_req = 1'b0;
        chk({tag, " valid"}, 32'(fetch_valid), 32'd1);
        chk({tag, " pc"}, 32'(fetch_pc), 32'(ref_fpc));
        chk({tag, " instr"}, fetch_instr, word_at(ref_fpc));
        chk({tag, " addr"}, 32'(imem_addr), 32'(ref_addr));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        br_req = 1'b1; br_kind = 2'b10; br_target = 9'h077;
        repeat (3) @(negedge clk);
        chk("R1 addr", 32'(imem_addr), 32'd0);
        chk("R1 valid", 32'(fetch_valid), 32'd0);
        rst_n = 1'b1;
        ref_addr = '0; ref_valid = 1'b0;
        chk("R2 invalid first cycle", 32'(fetch_valid), 32'd0);
        advance(1'b1, 2'b10, '0, 9'h077, "R11");
        chk("R11 request ignored", 32'(imem_addr), 32'd1);
        chk("R2 first pc", 32'(fetch_pc), 32'd0);
    endtask

    task automatic t_sequential;
        for (int i = 0; i < 5; i++) advance(1'b0, 2'b00, '0, '0, "R3");
        chk("R4 pc after run", 32'(fetch_pc), 32'd5);
    endtask

    task automatic t_if_zero;
        logic [AW-1:0] p = fetch_pc;
        advance(1'b1, 2'b00, '0, 9'h040, "R5");
        chk("R8 delay slot", 32'(fetch_pc), 32'(AW'(p + 1'b1)));
        advance(1'b0, 2'b00, '0, '0, "R5");
        chk("R5 target", 32'(fetch_pc), 32'h040);
        advance(1'b1, 2'b00, 32'h10, 9'h090, "R7");
        advance(1'b0, 2'b00, '0, '0, "R7");
        chk("R7 zero test fails", 32'(fetch_pc), 32'h042);
    endtask

    task automatic t_if_nonzero;
        logic [AW-1:0] p = fetch_pc;
        advance(1'b1, 2'b01, 32'h8000_0000, 9'h100, "R6");
        chk("R8 delay slot", 32'(fetch_pc), 32'(AW'(p + 1'b1)));
        advance(1'b0, 2'b00, '0, '0, "R6");
        chk("R6 target", 32'(fetch_pc), 32'h100);
        advance(1'b1, 2'b01, '0, 9'h0AA, "R7");
        advance(1'b0, 2'b00, '0, '0, "R7");
        chk("R7 nonzero test fails", 32'(fetch_pc), 32'h102);
    endtask

    task automatic t_jumps;
        advance(1'b1, 2'b10, 32'hFFFF_FFFF, 9'h1F0, "R9");
        advance(1'b0, 2'b00, '0, '0, "R9");
        chk("R9 direct jump", 32'(fetch_pc), 32'h1F0);
        advance(1'b1, 2'b11, 32'hABCD_E123, 9'h005, "R10");
        advance(1'b0, 2'b00, '0, '0, "R10");
        chk("R10 register jump", 32'(fetch_pc), 32'h123);
    endtask

    task automatic t_back_to_back;
        logic [AW-1:0] p = fetch_pc;
        advance(1'b1, 2'b10, '0, 9'h080, "R12");
        chk("R12 delay slot", 32'(fetch_pc), 32'(AW'(p + 1'b1)));
        advance(1'b1, 2'b00, '0, 9'h0C0, "R12");
        chk("R12 first target", 32'(fetch_pc), 32'h080);
        advance(1'b0, 2'b00, '0, '0, "R12");
        chk("R12 second target", 32'(fetch_pc), 32'h0C0);
    endtask

    task automatic t_wrap;
        advance(1'b1, 2'b10, '0, 9'h1FE, "R3");
        for (int i = 0; i < 3; i++) advance(1'b0, 2'b00, '0, '0, "R3");
        chk("R3 wrap to zero", 32'(fetch_pc), 32'h000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_if_zero();
        t_if_nonzero();
        t_jumps();
        t_back_to_back();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule